// File: doc/BRIEF.md
# Keyed Configuration Port for a Legacy I/O Controller

This block is the configuration front end of a legacy I/O controller on a byte-wide port bus. It exposes an index port and a data port at two consecutive addresses. Software writes a register number to the index port and then reads or writes that register through the data port. After reset the register space is sealed. It opens only when a fixed four-byte key is written to the index port. The last key byte depends on the base address the chip is strapped to.

Once open, the block gives access to a small set of global registers and to one register bank per logical device. The global registers are a chip identity pair, a logical-device selector and a serial-flash control byte. The register bank of the SPI logical device holds the 16-bit base address of the SPI engine. The flash control bits and the SPI base address are driven as outputs to the neighbouring logic. Writing a specific value to a specific register seals the block again.

Top module: `sio_cfg_unlock`

## Requirements
- R1: After reset the block is locked, `spi_base` is 0x0000, `flash_ctl` is 0x00, and a data-port read returns 0xFF.
- R2: With `strap_alt` low at reset, the port pair is 0x2E (index) and 0x2F (data). Writing 0x87, 0x01, 0x55, 0x55 in turn to 0x2E unlocks the block.
- R3: With `strap_alt` high at reset, the port pair is 0x4E and 0x4F, and the key ends in 0xAA instead of 0x55. A final 0x55 leaves the block locked.
- R4: A key byte that does not match restarts the matcher. If the wrong byte is 0x87, it counts as the first byte of a new attempt.
- R5: While locked, data-port reads return 0xFF, index-port reads return 0xFF, and data-port writes change no register.
- R6: `strap_alt` is sampled only during reset. Accesses at the other port pair are ignored: `io_rdata_vld` stays low and writes there have no effect.
- R7: When unlocked, index 0x20 reads 0x87 and index 0x21 reads 0x16 (chip identity 0x8716).
- R8: Index 0x24 is the flash control byte. Bits 5:0 are writable and drive `flash_ctl[5:0]`. Bits 7:6 read as 0. Bit 0 is suspend, bits 3:1 are segment enables, bit 4 is the flash write enable and bit 5 is the pin select.
- R9: Index 0x07 selects the logical device. When device 7 is selected, index 0x64 and 0x65 are the high and low bytes of `spi_base`. When another device is selected, writes to these indexes are ignored and reads return 0x00.
- R10: Writing 0x02 to index 0x02 locks the block. Any other value written to index 0x02 leaves it unlocked.
- R11: A read strobe at the port pair raises `io_rdata_vld` and updates `io_rdata` at the next clock edge. When unlocked, an index-port read returns the current index and an unmapped index reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_alt | input | 1 | Base select strap, sampled in reset: 0 for 0x2E, 1 for 0x4E |
| io_addr | input | 16 | Port bus address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| io_rdata_vld | output | 1 | High one cycle after a read the block claims |
| cfg_unlocked | output | 1 | Configuration space open |
| flash_ctl | output | 6 | Serial-flash control bits |
| spi_base | output | 16 | SPI engine base address |

## Verification
The bench checks the key matcher's restart rule. It sends a key whose wrong byte is 0x87 and a key with a doubled 0x87. A matcher that always restarts at zero would stay locked on the first; one that never resynchronises would stay locked on the second. It sends the 0x55 ending under the alternate strap; a design that ignores the strap would unlock. It toggles the strap without a reset; a design that samples the strap live would start answering at the other pair. It also writes the SPI base under a logical device other than 7, and writes a value other than 0x02 to the exit register. A design that does not decode the device number would corrupt the SPI base. A design that does not compare the written value would lock on any write to the exit register.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef logic [1:0] key_step_t;
  localparam key_step_t KEY_LAST = 2'd3;

  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_FLASH   = 8'h24;
  localparam logic [7:0] IDX_BASE_HI = 8'h64;
  localparam logic [7:0] IDX_BASE_LO = 8'h65;
  localparam logic [7:0] EXIT_VALUE  = 8'h02;
  localparam logic [7:0] KEY_FIRST   = 8'h87;

  // Expected key byte at a given step; the last byte depends on the strap.
  function automatic logic [7:0] key_byte(input key_step_t s, input logic alt);
    case (s)
      2'd0:    return KEY_FIRST;
      2'd1:    return 8'h01;
      2'd2:    return 8'h55;
      default: return alt ? 8'hAA : 8'h55;
    endcase
  endfunction

  // Next matcher step after byte b; a stray first-key byte resynchronises.
  function automatic key_step_t key_next(input key_step_t s, input logic [7:0] b,
                                         input logic alt);
    if (b == key_byte(s, alt)) return (s == KEY_LAST) ? 2'd0 : s + 2'd1;
    if (b == KEY_FIRST) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [15:0] port_base(input logic alt,
                                            input logic [15:0] pri,
                                            input logic [15:0] sec);
    return alt ? sec : pri;
  endfunction

endpackage

// File: rtl/sio_key_matcher.sv
module sio_key_matcher
  import sio_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      alt,
  input  logic      key_wr,
  input  logic [7:0] key_data,
  output key_step_t step,
  output logic      key_done
);

  key_step_t step_q;

  assign key_done = key_wr && (step_q == KEY_LAST) &&
                    (key_data == key_byte(step_q, alt));
  assign step = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= 2'd0;
    end else if (key_wr) begin
      step_q <= key_next(step_q, key_data, alt);
    end
  end

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter int          FLASH_W = 6,
  parameter int          BASE_W  = 16,
  parameter logic [15:0] CHIP_ID = 16'h8716,
  parameter logic [7:0]  SPI_LDN = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_wr,
  input  logic               dat_wr,
  input  logic [7:0]         wdata,
  output logic [7:0]         idx_q,
  output logic [7:0]         rd_val,
  output logic               exit_hit,
  output logic [FLASH_W-1:0] flash_ctl,
  output logic [BASE_W-1:0]  spi_base
);

  localparam int PAD_W = 8 - FLASH_W;

  logic [7:0]         ldn_q;
  logic [FLASH_W-1:0] flash_q;
  logic [BASE_W-1:0]  base_q;
  logic               spi_sel;

  assign spi_sel  = (ldn_q == SPI_LDN);
  assign exit_hit = dat_wr && (idx_q == IDX_EXIT) && (wdata == EXIT_VALUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 8'h00;
      ldn_q   <= 8'h00;
      flash_q <= '0;
      base_q  <= '0;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (dat_wr) begin
        case (idx_q)
          IDX_LDN:     ldn_q   <= wdata;
          IDX_FLASH:   flash_q <= wdata[FLASH_W-1:0];
          IDX_BASE_HI: if (spi_sel) base_q[BASE_W-1:8] <= wdata;
          IDX_BASE_LO: if (spi_sel) base_q[7:0]        <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_q)
      IDX_ID_HI:   rd_val = CHIP_ID[15:8];
      IDX_ID_LO:   rd_val = CHIP_ID[7:0];
      IDX_LDN:     rd_val = ldn_q;
      IDX_FLASH:   rd_val = {{PAD_W{1'b0}}, flash_q};
      IDX_BASE_HI: rd_val = spi_sel ? base_q[BASE_W-1:8] : 8'h00;
      IDX_BASE_LO: rd_val = spi_sel ? base_q[7:0] : 8'h00;
      default:     rd_val = 8'h00;
    endcase
  end

  assign flash_ctl = flash_q;
  assign spi_base  = base_q;

endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          FLASH_W  = 6,
  parameter int          BASE_W   = 16,
  parameter logic [15:0] PRI_BASE = 16'h002E,
  parameter logic [15:0] ALT_BASE = 16'h004E,
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter logic [7:0]  SPI_LDN  = 8'h07
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_alt,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic               io_rdata_vld,
  output logic               cfg_unlocked,
  output logic [FLASH_W-1:0] flash_ctl,
  output logic [BASE_W-1:0]  spi_base
);

  logic              alt_q;
  logic [ADDR_W-1:0] base_addr;
  logic              at_idx, at_dat;
  logic              rd_hit, rd_dat_hit;
  logic              key_wr, key_done;
  logic              idx_wr, dat_wr, exit_hit;
  key_step_t         key_step;
  logic [7:0]        idx_q, reg_val;
  logic              unlocked_q;
  logic [7:0]        rdata_q;
  logic              vld_q;

  // Strap is latched while reset is held and frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) alt_q <= strap_alt;
  end

  assign base_addr  = ADDR_W'(port_base(alt_q, PRI_BASE, ALT_BASE));
  assign at_idx     = (io_addr == base_addr);
  assign at_dat     = (io_addr == base_addr + ADDR_W'(1));
  assign rd_hit     = io_rd && (at_idx || at_dat);
  assign rd_dat_hit = io_rd && at_dat;
  assign key_wr     = io_wr && at_idx && !unlocked_q;
  assign idx_wr     = io_wr && at_idx && unlocked_q;
  assign dat_wr     = io_wr && at_dat && unlocked_q;

  sio_key_matcher u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .alt      (alt_q),
    .key_wr   (key_wr),
    .key_data (io_wdata),
    .step     (key_step),
    .key_done (key_done)
  );

  sio_reg_bank #(
    .FLASH_W (FLASH_W),
    .BASE_W  (BASE_W),
    .CHIP_ID (CHIP_ID),
    .SPI_LDN (SPI_LDN)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .dat_wr    (dat_wr),
    .wdata     (io_wdata),
    .idx_q     (idx_q),
    .rd_val    (reg_val),
    .exit_hit  (exit_hit),
    .flash_ctl (flash_ctl),
    .spi_base  (spi_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      rdata_q    <= 8'h00;
      vld_q      <= 1'b0;
    end else begin
      if (key_done)      unlocked_q <= 1'b1;
      else if (exit_hit) unlocked_q <= 1'b0;
      vld_q <= rd_hit;
      if (rd_hit) begin
        if (!unlocked_q) rdata_q <= 8'hFF;
        else if (at_idx) rdata_q <= idx_q;
        else             rdata_q <= reg_val;
      end
    end
  end

  assign cfg_unlocked = unlocked_q;
  assign io_rdata     = rdata_q;
  assign io_rdata_vld = vld_q;

endmodule

// File: rtl/sio_cfg_unlock_chk.sv
module sio_cfg_unlock_chk #(
  parameter int FLASH_W = 6,
  parameter int BASE_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_hit,
  input logic               rd_dat_hit,
  input logic [7:0]         io_rdata,
  input logic               io_rdata_vld,
  input logic               cfg_unlocked,
  input logic               key_done,
  input logic               exit_hit,
  input logic [1:0]         key_step,
  input logic [FLASH_W-1:0] flash_ctl,
  input logic [BASE_W-1:0]  spi_base
);

  p_locked_data_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && rd_dat_hit) |=> (io_rdata == 8'hFF));

  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked |=> ($stable(spi_base) && $stable(flash_ctl)));

  p_unlock_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(key_done));

  p_matcher_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_unlocked |-> (key_step == 2'd0));

  p_foreign_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> !io_rdata_vld);

  p_claim_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> io_rdata_vld);

  p_relock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> !cfg_unlocked);

endmodule

bind sio_cfg_unlock sio_cfg_unlock_chk #(
  .FLASH_W (FLASH_W),
  .BASE_W  (BASE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_hit       (rd_hit),
  .rd_dat_hit   (rd_dat_hit),
  .io_rdata     (io_rdata),
  .io_rdata_vld (io_rdata_vld),
  .cfg_unlocked (cfg_unlocked),
  .key_done     (key_done),
  .exit_hit     (exit_hit),
  .key_step     (key_step),
  .flash_ctl    (flash_ctl),
  .spi_base     (spi_base)
);

// File: tb/sio_cfg_unlock_bench.sv
module sio_cfg_unlock_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        io_rdata_vld;
  logic        cfg_unlocked;
  logic [5:0]  flash_ctl;
  logic [15:0] spi_base;

  int nvec = 0;
  int nerr = 0;
  logic [7:0] rd_byte;
  logic       rd_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_unlock u_sio_cfg_unlock (
    .clk (clk), .rst_n (rst_n), .strap_alt (strap_alt),
    .io_addr (io_addr), .io_wr (io_wr), .io_rd (io_rd), .io_wdata (io_wdata),
    .io_rdata (io_rdata), .io_rdata_vld (io_rdata_vld),
    .cfg_unlocked (cfg_unlocked), .flash_ctl (flash_ctl), .spi_base (spi_base)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    strap_alt = alt;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    rd_byte = io_rdata;
    rd_vld  = io_rdata_vld;
  endtask

  task automatic cfg_wr(input logic [15:0] b, input logic [7:0] idx, input logic [7:0] d);
    wr(b, idx);
    wr(b + 16'd1, d);
  endtask

  task automatic cfg_rd(input logic [15:0] b, input logic [7:0] idx);
    wr(b, idx);
    rd(b + 16'd1);
  endtask

  task automatic send_key(input logic [15:0] b, input logic [7:0] k0, input logic [7:0] k1,
                          input logic [7:0] k2, input logic [7:0] k3);
    wr(b, k0); wr(b, k1); wr(b, k2); wr(b, k3);
  endtask

  task automatic t_reset_state;
    check("R1 locked", {15'd0, cfg_unlocked}, 16'd0);
    check("R1 spi_base", spi_base, 16'h0000);
    check("R1 flash_ctl", {10'd0, flash_ctl}, 16'h0000);
    rd(16'h002F);
    check("R1 data read", {8'd0, rd_byte}, 16'h00FF);
  endtask

  task automatic t_locked_ignore;
    cfg_wr(16'h002E, 8'h24, 8'h3F);
    check("R5 flash_ctl after locked write", {10'd0, flash_ctl}, 16'h0000);
    rd(16'h002E);
    check("R5 locked index read", {8'd0, rd_byte}, 16'h00FF);
    rd(16'h002F);
    check("R5 locked data read", {8'd0, rd_byte}, 16'h00FF);
  endtask

  task automatic t_unlock_primary;
    send_key(16'h002E, 8'h87, 8'h01, 8'h55, 8'h55);
    check("R2 unlocked by primary key", {15'd0, cfg_unlocked}, 16'd1);
  endtask

  task automatic t_chip_id;
    cfg_rd(16'h002E, 8'h20);
    check("R7 id high", {8'd0, rd_byte}, 16'h0087);
    cfg_rd(16'h002E, 8'h21);
    check("R7 id low", {8'd0, rd_byte}, 16'h0016);
  endtask

  task automatic t_read_path;
    rd(16'h002E);
    check("R11 index read", {8'd0, rd_byte}, 16'h0021);
    check("R11 valid", {15'd0, rd_vld}, 16'd1);
    @(negedge clk);
    check("R11 valid drops", {15'd0, io_rdata_vld}, 16'd0);
    cfg_rd(16'h002E, 8'h30);
    check("R11 unmapped index", {8'd0, rd_byte}, 16'h0000);
  endtask

  task automatic t_flash_ctl;
    cfg_wr(16'h002E, 8'h24, 8'hFF);
    check("R8 flash_ctl out", {10'd0, flash_ctl}, 16'h003F);
    rd(16'h002F);
    check("R8 flash readback", {8'd0, rd_byte}, 16'h003F);
    cfg_wr(16'h002E, 8'h24, 8'h12);
    check("R8 flash_ctl pattern", {10'd0, flash_ctl}, 16'h0012);
  endtask

  task automatic t_spi_base;
    cfg_wr(16'h002E, 8'h07, 8'h03);
    cfg_wr(16'h002E, 8'h64, 8'hAB);
    check("R9 other device write ignored", spi_base, 16'h0000);
    rd(16'h002F);
    check("R9 other device read zero", {8'd0, rd_byte}, 16'h0000);
    cfg_wr(16'h002E, 8'h07, 8'h07);
    cfg_wr(16'h002E, 8'h64, 8'h12);
    cfg_wr(16'h002E, 8'h65, 8'h34);
    check("R9 spi_base", spi_base, 16'h1234);
    cfg_rd(16'h002E, 8'h64);
    check("R9 base high readback", {8'd0, rd_byte}, 16'h0012);
    cfg_rd(16'h002E, 8'h07);
    check("R9 device select readback", {8'd0, rd_byte}, 16'h0007);
  endtask

  task automatic t_relock;
    cfg_wr(16'h002E, 8'h02, 8'h01);
    check("R10 other value keeps open", {15'd0, cfg_unlocked}, 16'd1);
    cfg_wr(16'h002E, 8'h02, 8'h02);
    check("R10 relocked", {15'd0, cfg_unlocked}, 16'd0);
    cfg_rd(16'h002E, 8'h20);
    check("R10 read after relock", {8'd0, rd_byte}, 16'h00FF);
  endtask

  task automatic t_restart;
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h01);
    send_key(16'h002E, 8'h87, 8'h01, 8'h55, 8'h55);
    check("R4 0x87 restarts attempt", {15'd0, cfg_unlocked}, 16'd1);
    cfg_wr(16'h002E, 8'h02, 8'h02);
    send_key(16'h002E, 8'h87, 8'h01, 8'h55, 8'h00);
    wr(16'h002E, 8'h55);
    check("R4 wrong byte restarts at zero", {15'd0, cfg_unlocked}, 16'd0);
    wr(16'h002E, 8'h87);
    send_key(16'h002E, 8'h87, 8'h01, 8'h55, 8'h55);
    check("R4 doubled 0x87", {15'd0, cfg_unlocked}, 16'd1);
    cfg_wr(16'h002E, 8'h02, 8'h02);
  endtask

  task automatic t_strap_frozen;
    @(negedge clk);
    strap_alt = 1'b1;
    send_key(16'h004E, 8'h87, 8'h01, 8'h55, 8'hAA);
    check("R6 strap change without reset", {15'd0, cfg_unlocked}, 16'd0);
    rd(16'h004F);
    check("R6 other pair no response", {15'd0, rd_vld}, 16'd0);
  endtask

  task automatic t_alt_strap;
    do_reset(1'b1);
    send_key(16'h004E, 8'h87, 8'h01, 8'h55, 8'h55);
    check("R3 0x55 ending rejected", {15'd0, cfg_unlocked}, 16'd0);
    send_key(16'h004E, 8'h87, 8'h01, 8'h55, 8'hAA);
    check("R3 alt key unlocks", {15'd0, cfg_unlocked}, 16'd1);
    rd(16'h002F);
    check("R6 primary pair silent", {15'd0, rd_vld}, 16'd0);
    cfg_wr(16'h002E, 8'h24, 8'h3F);
    check("R6 primary pair write ignored", {10'd0, flash_ctl}, 16'h0000);
    cfg_rd(16'h004E, 8'h20);
    check("R3 id at alt pair", {8'd0, rd_byte}, 16'h0087);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nvec++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    do_reset(1'b0);
    t_reset_state();
    t_locked_ignore();
    t_unlock_primary();
    t_chip_id();
    t_read_path();
    t_flash_ctl();
    t_spi_base();
    t_relock();
    t_restart();
    t_strap_frozen();
    t_alt_strap();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule